// File: doc/BRIEF.md
# Word-Aligned Hybrid Bitmap Encoder

This block compresses an uncompressed bitmap presented as a stream of fixed-width chunks. Each chunk is one bit narrower than a code word. A chunk whose bits are neither all clear nor all set leaves the block as a literal word. Consecutive chunks that are all clear, or all set, are gathered into a single fill word that records the repeated bit value and how many chunks it stands for.

Both sides use a valid/ready handshake. The input carries a flag that marks the final chunk of a bitmap. When that chunk is accepted, the encoder closes any run it still holds and tags the last code word of the bitmap with an output end flag. A single chunk can produce two words: the fill that closes a run and then a literal or a one-chunk fill. The block queues the second word internally and holds off its input until that word has left.

Top module: `wahenc_top`

## Requirements
- R1: A chunk containing both set and clear bits is emitted as a literal: bit CHUNK_W (the top bit) is 0 and bits CHUNK_W-1..0 are the chunk unchanged.
- R2: A fill word has its top bit 1, bit CHUNK_W-1 equal to the repeated bit value, and bits CHUNK_W-2..0 equal to the number of chunks it represents, which is never zero.
- R3: Consecutive all-clear chunks, or consecutive all-set chunks, produce one fill word whose count equals the number of such chunks.
- R4: A uniform chunk whose value differs from the open run emits the open run's fill and starts a new run with a count of 1.
- R5: A mixed chunk arriving while a run is open emits that run's fill first and its own literal immediately after it.
- R6: A run holding the maximum count 2^(CHUNK_W-1)-1 is emitted when a further chunk of the same value arrives, and that chunk starts a new run with a count of 1.
- R7: On acceptance of a chunk flagged as last, every pending word of the bitmap is emitted, out_last is 1 on the final word only, and the next chunk begins a fresh bitmap with no open run.
- R8: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values and in_ready is 0. Across any pattern of stalls no word is lost, duplicated or reordered.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input chunk is present |
| in_ready | output | 1 | Encoder takes the chunk on this cycle |
| in_data | input | CHUNK_W | Uncompressed chunk |
| in_last | input | 1 | Chunk is the final one of the bitmap |
| out_valid | output | 1 | Code word is present |
| out_ready | input | 1 | Consumer takes the code word |
| out_data | output | CHUNK_W+1 | Literal or fill code word |
| out_last | output | 1 | Code word is the final one of the bitmap |

## Verification
The properties let out_ready change freely on any cycle. They assume only that the source presents chunks through the handshake and that each bitmap ends with a flagged chunk, so that run-merging can be judged between successive fills of the same bitmap. The bench keeps each chunk and its last flag stable until in_ready takes it. It drops out_ready on a pseudo-random share of cycles, and it ends every stream with a flagged chunk. A narrow chunk width makes both the full chunk space and the saturation count reachable within a short run.

// File: rtl/wahenc_pkg.sv
package wahenc_pkg;

  typedef enum logic [1:0] {
    CLS_MIXED = 2'd0,
    CLS_ZERO  = 2'd1,
    CLS_ONE   = 2'd2
  } chunk_cls_e;

endpackage

// File: rtl/wahenc_rstsync.sv
module wahenc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/wahenc_classify.sv
module wahenc_classify
  import wahenc_pkg::*;
#(
  parameter int CHUNK_W = 31
) (
  input  logic [CHUNK_W-1:0] chunk,
  output chunk_cls_e         cls
);

  logic all_set;
  logic any_set;

  assign all_set = &chunk;
  assign any_set = |chunk;

  always_comb begin
    if (all_set)      cls = CLS_ONE;
    else if (!any_set) cls = CLS_ZERO;
    else               cls = CLS_MIXED;
  end

endmodule

// File: rtl/wahenc_run.sv
module wahenc_run
  import wahenc_pkg::*;
#(
  parameter int CHUNK_W = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  chunk_cls_e         cls,
  input  logic [CHUNK_W-1:0] chunk,
  input  logic               last,
  output logic               flush_v,
  output logic [CHUNK_W:0]   flush_w,
  output logic               tail_v,
  output logic [CHUNK_W:0]   tail_w,
  output logic               tail_last
);

  localparam int CNT_W = CHUNK_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             open_q, open_d;
  logic             val_q,  val_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;

  logic             uni;
  logic             bit_v;
  logic             extend;
  logic [CNT_W-1:0] new_cnt;

  assign uni    = (cls != CLS_MIXED);
  assign bit_v  = (cls == CLS_ONE);
  assign extend = open_q && (val_q == bit_v) && (cnt_q != CNT_MAX);
  assign new_cnt = extend ? (cnt_q + CNT_ONE) : CNT_ONE;

  always_comb begin
    flush_v   = open_q;
    flush_w   = {1'b1, val_q, cnt_q};
    tail_v    = 1'b1;
    tail_w    = {1'b0, chunk};
    tail_last = last;
    open_d    = 1'b0;
    val_d     = val_q;
    cnt_d     = cnt_q;
    if (uni) begin
      flush_v = open_q && !extend;
      tail_v  = last;
      tail_w  = {1'b1, bit_v, new_cnt};
      open_d  = !last;
      val_d   = bit_v;
      cnt_d   = new_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      val_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (take) begin
      open_q <= open_d;
      val_q  <= val_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/wahenc_emit.sv
module wahenc_emit #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              flush_v,
  input  logic [WORD_W-1:0] flush_w,
  input  logic              tail_v,
  input  logic [WORD_W-1:0] tail_w,
  input  logic              tail_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              slot_free
);

  logic              out_v_q, out_v_d;
  logic [WORD_W-1:0] out_d_q, out_d_d;
  logic              out_l_q, out_l_d;
  logic              pend_v_q, pend_v_d;
  logic [WORD_W-1:0] pend_d_q, pend_d_d;
  logic              pend_l_q, pend_l_d;
  logic              out_free;
  logic              out_en;
  logic              pend_en;

  assign out_free  = !out_v_q || out_ready;
  assign slot_free = !pend_v_q && out_free;

  always_comb begin
    out_v_d  = out_v_q;
    out_d_d  = out_d_q;
    out_l_d  = out_l_q;
    pend_v_d = pend_v_q;
    pend_d_d = pend_d_q;
    pend_l_d = pend_l_q;
    if (out_free) begin
      if (pend_v_q) begin
        out_v_d  = 1'b1;
        out_d_d  = pend_d_q;
        out_l_d  = pend_l_q;
        pend_v_d = 1'b0;
      end else if (take && flush_v) begin
        out_v_d  = 1'b1;
        out_d_d  = flush_w;
        out_l_d  = 1'b0;
        pend_v_d = tail_v;
        pend_d_d = tail_w;
        pend_l_d = tail_last;
      end else if (take && tail_v) begin
        out_v_d = 1'b1;
        out_d_d = tail_w;
        out_l_d = tail_last;
      end else begin
        out_v_d = 1'b0;
      end
    end
  end

  assign out_en  = out_free;
  assign pend_en = out_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_d_q <= '0;
      out_l_q <= 1'b0;
    end else if (out_en) begin
      out_v_q <= out_v_d;
      out_d_q <= out_d_d;
      out_l_q <= out_l_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
      pend_l_q <= 1'b0;
    end else if (pend_en) begin
      pend_v_q <= pend_v_d;
      pend_d_q <= pend_d_d;
      pend_l_q <= pend_l_d;
    end
  end

  assign out_valid = out_v_q;
  assign out_data  = out_d_q;
  assign out_last  = out_l_q;

endmodule

// File: rtl/wahenc_top.sv
module wahenc_top
  import wahenc_pkg::*;
#(
  parameter int CHUNK_W = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CHUNK_W-1:0] in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CHUNK_W:0]   out_data,
  output logic               out_last
);

  localparam int WORD_W = CHUNK_W + 1;

  logic              rst_sync_n;
  chunk_cls_e        cls;
  logic              take;
  logic              slot_free;
  logic              flush_v;
  logic [WORD_W-1:0] flush_w;
  logic              tail_v;
  logic [WORD_W-1:0] tail_w;
  logic              tail_last;

  assign in_ready = slot_free;
  assign take     = in_valid && slot_free;

  wahenc_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wahenc_classify #(.CHUNK_W(CHUNK_W)) u_classify (
    .chunk (in_data),
    .cls   (cls)
  );

  wahenc_run #(.CHUNK_W(CHUNK_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (take),
    .cls       (cls),
    .chunk     (in_data),
    .last      (in_last),
    .flush_v   (flush_v),
    .flush_w   (flush_w),
    .tail_v    (tail_v),
    .tail_w    (tail_w),
    .tail_last (tail_last)
  );

  wahenc_emit #(.WORD_W(WORD_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (take),
    .flush_v   (flush_v),
    .flush_w   (flush_w),
    .tail_v    (tail_v),
    .tail_w    (tail_w),
    .tail_last (tail_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .slot_free (slot_free)
  );

endmodule

// File: rtl/wahenc_chk.sv
module wahenc_chk #(
  parameter int CHUNK_W = 31
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CHUNK_W:0]   out_data,
  input logic               out_last
);

  localparam int CNT_W = CHUNK_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             prev_fill_q;
  logic             prev_val_q;
  logic [CNT_W-1:0] prev_cnt_q;
  logic             prev_last_q;
  logic             xfer;

  assign xfer = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fill_q <= 1'b0;
      prev_val_q  <= 1'b0;
      prev_cnt_q  <= '0;
      prev_last_q <= 1'b1;
    end else if (xfer) begin
      prev_fill_q <= out_data[CHUNK_W];
      prev_val_q  <= out_data[CHUNK_W-1];
      prev_cnt_q  <= out_data[CNT_W-1:0];
      prev_last_q <= out_last;
    end
  end

  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r2_fill_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[CHUNK_W] |-> (out_data[CNT_W-1:0] != '0));

  a_r1_literal_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_data[CHUNK_W] |-> (|out_data[CHUNK_W-1:0]) && !(&out_data[CHUNK_W-1:0]));

  a_r3_fills_merged: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && out_data[CHUNK_W] && prev_fill_q && !prev_last_q &&
    (prev_val_q == out_data[CHUNK_W-1]) |-> (prev_cnt_q == CNT_MAX));

endmodule

bind wahenc_top wahenc_chk #(.CHUNK_W(CHUNK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/test_wahenc_top.sv
module test_wahenc_top;

  localparam int CW = 7;
  localparam int WW = CW + 1;
  localparam int MAXC = (1 << (CW - 1)) - 1;
  localparam int CLK_PERIOD = 10;
  localparam int NSTIM = 4096;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [CW-1:0] in_data;
  logic          in_last;
  logic          out_valid;
  logic          out_ready;
  logic [WW-1:0] out_data;
  logic          out_last;

  int checks;
  int failures;
  string cur_tag;

  logic [CW-1:0] stim [NSTIM];
  logic [WW:0]   exp_q [$];

  bit m_open;
  bit m_val;
  int m_cnt;

  wahenc_top #(.CHUNK_W(CW)) i_wahenc_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [WW-1:0] fill_word(input bit v, input int cnt);
    return WW'((1 << (WW - 1)) | (int'(v) << (WW - 2)) | cnt);
  endfunction

  function automatic void model_push(input logic [CW-1:0] c, input bit last);
    bit uni;
    bit v;
    uni = (c == '0) || (c == '1);
    v   = c[0];
    if (uni) begin
      if (m_open && m_val == v && m_cnt < MAXC) begin
        m_cnt++;
      end else begin
        if (m_open) exp_q.push_back({1'b0, fill_word(m_val, m_cnt)});
        m_open = 1'b1;
        m_val  = v;
        m_cnt  = 1;
      end
      if (last) begin
        exp_q.push_back({1'b1, fill_word(m_val, m_cnt)});
        m_open = 1'b0;
      end
    end else begin
      if (m_open) exp_q.push_back({1'b0, fill_word(m_val, m_cnt)});
      m_open = 1'b0;
      exp_q.push_back({last, 1'b0, c});
    end
  endfunction

  task automatic run_stream(input int n, input string tag, input bit bp);
    int idx;
    int guard;
    bit hold_v;
    logic [WW:0] hold_d;
    logic [WW:0] e;
    idx = 0;
    guard = 0;
    hold_v = 1'b0;
    hold_d = '0;
    cur_tag = tag;
    while ((idx < n || exp_q.size() != 0 || out_valid) && guard < 40000) begin
      @(negedge clk);
      in_valid  = (idx < n);
      in_data   = stim[(idx < n) ? idx : 0];
      in_last   = (idx == n - 1);
      out_ready = bp ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (hold_v) begin
        check(out_valid && ({out_last, out_data} == hold_d), "R8", int'({out_last, out_data}), int'(hold_d));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, {cur_tag, " extra word"}, int'({out_last, out_data}), 0);
        end else begin
          e = exp_q.pop_front();
          check({out_last, out_data} == e, cur_tag, int'({out_last, out_data}), int'(e));
        end
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R8", int'(in_ready), 0);
        hold_v = 1'b1;
        hold_d = {out_last, out_data};
      end else begin
        hold_v = 1'b0;
      end
      if (in_valid && in_ready) begin
        model_push(stim[idx], idx == n - 1);
        idx++;
      end
      guard++;
    end
    check(guard < 40000, {tag, " stream completion"}, guard, 0);
    @(negedge clk);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    m_open = 1'b0;
    m_val = 1'b0;
    m_cnt = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_last = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R9: idle after reset
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9", int'(in_ready), 1);

    // R1: mixed chunks become literals
    stim[0] = 7'h2A; stim[1] = 7'h01; stim[2] = 7'h7E;
    run_stream(3, "R1", 1'b0);

    // R3, R4, R7: two runs of different value
    for (int i = 0; i < 5; i++) stim[i] = '0;
    for (int i = 5; i < 8; i++) stim[i] = '1;
    run_stream(8, "R4", 1'b0);

    // R5: run closed by mixed chunk
    for (int i = 0; i < 3; i++) stim[i] = '1;
    stim[3] = 7'h33;
    run_stream(4, "R5", 1'b0);

    // R6: saturation of the run count
    for (int i = 0; i < 2 * MAXC + 2; i++) stim[i] = '0;
    run_stream(2 * MAXC + 2, "R6", 1'b0);
    for (int i = 0; i < MAXC; i++) stim[i] = '1;
    run_stream(MAXC, "R6", 1'b1);

    // R1, R2, R7: every chunk value as a one-chunk bitmap
    for (int v = 0; v < (1 << CW); v++) begin
      stim[0] = CW'(v);
      run_stream(1, ((v == 0) || (v == (1 << CW) - 1)) ? "R2" : "R1", (v % 2) == 1);
    end

    // R3, R4, R5, R7: every chunk followed by each kind of second chunk
    for (int a = 0; a < (1 << CW); a++) begin
      for (int k = 0; k < 3; k++) begin
        stim[0] = CW'(a);
        stim[1] = (k == 0) ? '0 : (k == 1) ? '1 : 7'h55;
        run_stream(2, "R3", k == 2);
      end
    end

    // R8: long mixed stream under backpressure with long uniform runs
    begin
      int pos;
      pos = 0;
      while (pos < NSTIM - 100) begin
        int kind;
        int len;
        kind = $urandom % 3;
        len  = 1 + ($urandom % 80);
        for (int j = 0; j < len; j++) begin
          stim[pos] = (kind == 0) ? '0 : (kind == 1) ? '1 : CW'($urandom);
          pos++;
        end
      end
      run_stream(pos, "R8", 1'b1);
    end

    @(negedge clk);
    #1;
    // R7: nothing left after the final word
    check(out_valid == 1'b0 && exp_q.size() == 0, "R7", int'(out_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule